// File: doc/BRIEF.md
# Paged Table Read Unit

This block reads constants out of a program memory whose words are 24 bits wide and hands them to a 16-bit datapath. A software-visible page register supplies the top eight bits of a 24-bit address and the requester supplies a 16-bit pointer. The block reads the 24-bit word at that address through a synchronous memory port. It then returns one of four views of it as a zero-extended 16-bit result, with a one-cycle done strobe.

The requester sees the program word as two 16-bit lanes that sit side by side at the same addresses. The low lane holds word bits 15:0. The high lane holds bits 23:16 in its low byte, and its upper byte does not exist: it always reads as zero. In word mode, pointer bit 0 has no effect. In byte mode, it picks the byte within the lane. Each read takes five cycles. The block handles one read at a time and drops any request that arrives while a read is in progress.

Top module: `paged_table_reader`

## Requirements
- R1: After reset the page register holds 0x00. A write through `pg_wr_en`/`pg_wr_data` loads it. `pg_rd_data` returns the page in bits 7:0, and bits 15:8 always read as zero.
- R2: In the cycle after a request is accepted, `mem_rd_en` is 1 for exactly one cycle. `mem_addr` then carries {page, pointer[15:1]}, so page bit 7 appears on `mem_addr[22]` and selects the configuration half of the space.
- R3: The page bits on `mem_addr[22:15]` come from the page register alone. No pointer value carries into them or borrows from them, including pointers 0xFFFF and 0x0000.
- R4: A low-lane word read (`req_hi`=0, `req_byte`=0) returns word bits 15:0. Pointer bit 0 is ignored.
- R5: A low-lane byte read returns {8'h00, word[7:0]} when pointer bit 0 is 0, and {8'h00, word[15:8]} when it is 1.
- R6: A high-lane word read (`req_hi`=1, `req_byte`=0) returns {8'h00, word[23:16]}. The missing upper byte reads as zero.
- R7: A high-lane byte read returns {8'h00, word[23:16]} when pointer bit 0 is 0, and 16'h0000 when it is 1.
- R8: `done` rises five clock edges after the edge that accepts a request and stays high for exactly one cycle. `result` updates on that same edge.
- R9: `busy` is high from the cycle after acceptance until `done` rises. A request made while `busy` is high starts no memory read and does not change the result.
- R10: `result` holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_wr_en | input | 1 | Page register write strobe |
| pg_wr_data | input | 8 | New page value |
| pg_rd_data | output | 16 | Page register readback, upper byte zero |
| req_valid | input | 1 | Read request |
| req_ptr | input | 16 | Pointer, bit 0 is byte select |
| req_hi | input | 1 | 1 selects the high lane, 0 the low lane |
| req_byte | input | 1 | 1 selects byte mode, 0 word mode |
| busy | output | 1 | Read in progress |
| mem_rd_en | output | 1 | Program memory read enable |
| mem_addr | output | 23 | Program memory word address |
| mem_rdata | input | 24 | Program memory data, one cycle after `mem_rd_en` |
| done | output | 1 | Result valid strobe |
| result | output | 16 | Zero-extended read result |

## Verification
The bench counts every edge from the one that samples the request. It samples all outputs at the falling edge that follows each rising edge. The memory read with its address is due one edge after acceptance and must be gone one edge later. The result and `done` are due at the fifth edge, and `done` must be low again at the sixth. The bench checks `done` low and `busy` high at each edge in between. A page readback is due one edge after its write. Expected words come from an address-hashing function in the bench's memory model. Each result is predicted from that word and the requested view.

// File: rtl/tbl_rd_pkg.sv
package tbl_rd_pkg;
  typedef enum logic {LANE_LO = 1'b0, LANE_HI = 1'b1} lane_e;

  typedef struct packed {
    lane_e lane;
    logic  byte_mode;
    logic  sel_odd;
  } rd_kind_t;
endpackage

// File: rtl/tbl_page_reg.sv
module tbl_page_reg #(
  parameter int PAGE_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [PAGE_W-1:0] page,
  output logic [REG_W-1:0]  rd_data
);
  logic [PAGE_W-1:0] page_q, page_d;

  always_comb begin
    page_d = page_q;
    if (wr_en) page_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  assign page    = page_q;
  assign rd_data = REG_W'(page_q);
endmodule

// File: rtl/tbl_rd_seq.sv
module tbl_rd_seq #(
  parameter int READ_CYCLES = 5,
  parameter int MEM_LAT     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic busy,
  output logic cap_en,
  output logic fin
);
  localparam int CNT_W = $clog2(READ_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(READ_CYCLES - 1);
  localparam logic [CNT_W-1:0] CAP_IDX = CNT_W'(MEM_LAT);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy   = busy_q;
  assign cap_en = busy_q && (cnt_q == CAP_IDX);
  assign fin    = busy_q && (cnt_q == LAST);
endmodule

// File: rtl/tbl_lane_extract.sv
module tbl_lane_extract
  import tbl_rd_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int DATA_W = 16
) (
  input  logic [WORD_W-1:0] raw,
  input  rd_kind_t          kind,
  output logic [DATA_W-1:0] value
);
  localparam int BYTE_W = 8;
  localparam int HI_W   = WORD_W - DATA_W;

  always_comb begin
    value = '0;
    if (kind.lane == LANE_LO) begin
      if (kind.byte_mode)
        value[BYTE_W-1:0] = kind.sel_odd ? raw[2*BYTE_W-1:BYTE_W] : raw[BYTE_W-1:0];
      else
        value = raw[DATA_W-1:0];
    end else begin
      if (!(kind.byte_mode && kind.sel_odd))
        value[HI_W-1:0] = raw[WORD_W-1 -: HI_W];
    end
  end
endmodule

// File: rtl/paged_table_reader.sv
module paged_table_reader
  import tbl_rd_pkg::*;
#(
  parameter int PAGE_W      = 8,
  parameter int PTR_W       = 16,
  parameter int WORD_W      = 24,
  parameter int DATA_W      = 16,
  parameter int READ_CYCLES = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pg_wr_en,
  input  logic [PAGE_W-1:0]        pg_wr_data,
  output logic [DATA_W-1:0]        pg_rd_data,
  input  logic                     req_valid,
  input  logic [PTR_W-1:0]         req_ptr,
  input  logic                     req_hi,
  input  logic                     req_byte,
  output logic                     busy,
  output logic                     mem_rd_en,
  output logic [PAGE_W+PTR_W-2:0]  mem_addr,
  input  logic [WORD_W-1:0]        mem_rdata,
  output logic                     done,
  output logic [DATA_W-1:0]        result
);
  localparam int MADDR_W = PAGE_W + PTR_W - 1;

  logic [PAGE_W-1:0] page;
  logic              accept, cap_en, fin;
  logic [DATA_W-1:0] view;

  logic [MADDR_W-1:0] addr_q, addr_d;
  logic               rden_q, rden_d;
  rd_kind_t           kind_q, kind_d;
  logic [WORD_W-1:0]  raw_q, raw_d;
  logic [DATA_W-1:0]  res_q, res_d;
  logic               done_q, done_d;

  tbl_page_reg #(.PAGE_W(PAGE_W), .REG_W(DATA_W)) page_i (
    .clk(clk), .rst_n(rst_n), .wr_en(pg_wr_en), .wr_data(pg_wr_data),
    .page(page), .rd_data(pg_rd_data)
  );

  tbl_rd_seq #(.READ_CYCLES(READ_CYCLES), .MEM_LAT(1)) seq_i (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .busy(busy), .cap_en(cap_en), .fin(fin)
  );

  tbl_lane_extract #(.WORD_W(WORD_W), .DATA_W(DATA_W)) ext_i (
    .raw(raw_q), .kind(kind_q), .value(view)
  );

  assign accept = req_valid && !busy;

  always_comb begin
    addr_d = addr_q;
    kind_d = kind_q;
    raw_d  = raw_q;
    res_d  = res_q;
    rden_d = accept;
    done_d = fin;
    if (accept) begin
      addr_d = {page, req_ptr[PTR_W-1:1]};
      kind_d = '{lane: lane_e'(req_hi), byte_mode: req_byte, sel_odd: req_ptr[0]};
    end
    if (cap_en) raw_d = mem_rdata;
    if (fin)    res_d = view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rden_q <= 1'b0;
      kind_q <= '0;
      raw_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      rden_q <= rden_d;
      kind_q <= kind_d;
      raw_q  <= raw_d;
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign mem_rd_en = rden_q;
  assign mem_addr  = addr_q;
  assign done      = done_q;
  assign result    = res_q;
endmodule

// File: rtl/paged_table_reader_chk.sv
module paged_table_reader_chk #(
  parameter int PAGE_W      = 8,
  parameter int PTR_W       = 16,
  parameter int DATA_W      = 16,
  parameter int READ_CYCLES = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DATA_W-1:0]       pg_rd_data,
  input logic                    req_valid,
  input logic                    busy,
  input logic                    mem_rd_en,
  input logic [PAGE_W+PTR_W-2:0] mem_addr,
  input logic                    done,
  input logic [DATA_W-1:0]       result
);
  localparam int CW = $clog2(READ_CYCLES + 3);
  localparam logic [CW-1:0] DONE_AT = CW'(READ_CYCLES + 1);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_q <= '0;
    else if (req_valid && !busy)         since_q <= CW'(1);
    else if (since_q != '0 && since_q != DONE_AT) since_q <= since_q + 1'b1;
  end

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R3
  page_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_addr[PAGE_W+PTR_W-2 -: PAGE_W] == $past(pg_rd_data[PAGE_W-1:0]));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> since_q == DONE_AT);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> !mem_rd_en);

  // R9
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind paged_table_reader paged_table_reader_chk #(
  .PAGE_W(PAGE_W), .PTR_W(PTR_W), .DATA_W(DATA_W), .READ_CYCLES(READ_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pg_rd_data(pg_rd_data), .req_valid(req_valid),
  .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .done(done),
  .result(result)
);

// File: tb/paged_table_reader_tb_top.sv
`timescale 1ns/1ps
module paged_table_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pg_wr_en;
  logic [7:0]  pg_wr_data;
  logic [15:0] pg_rd_data;
  logic        req_valid;
  logic [15:0] req_ptr;
  logic        req_hi;
  logic        req_byte;
  logic        busy;
  logic        mem_rd_en;
  logic [22:0] mem_addr;
  logic [23:0] mem_rdata;
  logic        done;
  logic [15:0] result;

  int total = 0;
  int bad   = 0;
  logic [7:0] page_m = 8'h00;
  bit finished = 0;

  always #4 clk = ~clk;

  paged_table_reader dut_i (
    .clk(clk), .rst_n(rst_n), .pg_wr_en(pg_wr_en), .pg_wr_data(pg_wr_data),
    .pg_rd_data(pg_rd_data), .req_valid(req_valid), .req_ptr(req_ptr),
    .req_hi(req_hi), .req_byte(req_byte), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .result(result)
  );

  function automatic logic [23:0] memf(input logic [22:0] a);
    return {a[7:0] ^ 8'hC3, a[15:0] ^ {a[22:15], a[7:0]} ^ 16'h9E37};
  endfunction

  function automatic logic [15:0] expv(input logic [23:0] w, input logic hi,
                                       input logic byt, input logic odd);
    if (!hi) return byt ? {8'h00, (odd ? w[15:8] : w[7:0])} : w[15:0];
    return (byt && odd) ? 16'h0000 : {8'h00, w[23:16]};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_page(input logic [7:0] v);
    @(negedge clk); pg_wr_en = 1'b1; pg_wr_data = v;
    @(posedge clk); @(negedge clk); pg_wr_en = 1'b0;
    page_m = v;
    chk("R1 page readback", {16'h0, pg_rd_data}, {24'h0, v});
  endtask

  task automatic do_read(input logic [15:0] ptr, input logic hi, input logic byt,
                         input logic inject);
    logic [22:0] ea   = {page_m, ptr[15:1]};
    logic [15:0] ev   = expv(memf(ea), hi, byt, ptr[0]);
    string       tag  = hi ? (byt ? "R7 hi byte" : "R6 hi word")
                           : (byt ? "R5 lo byte" : "R4 lo word");
    @(negedge clk);
    req_valid = 1'b1; req_ptr = ptr; req_hi = hi; req_byte = byt;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rd_en", {31'h0, mem_rd_en}, 32'h1);
    chk("R2 addr", {9'h0, mem_addr}, {9'h0, ea});
    chk("R9 busy", {31'h0, busy}, 32'h1);
    if (inject) begin
      req_valid = 1'b1; req_ptr = ptr ^ 16'h5555; req_hi = ~hi; req_byte = ~byt;
    end
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rd_en single", {31'h0, mem_rd_en}, 32'h0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 done early", {31'h0, done}, 32'h0);
      chk("R9 busy held", {31'h0, busy}, 32'h1);
      if (inject) chk("R9 ignored no read", {31'h0, mem_rd_en}, 32'h0);
    end
    @(posedge clk); @(negedge clk);
    chk("R8 done", {31'h0, done}, 32'h1);
    chk("R9 busy off", {31'h0, busy}, 32'h0);
    chk(tag, {16'h0, result}, {16'h0, ev});
    @(posedge clk); @(negedge clk);
    chk("R8 done pulse", {31'h0, done}, 32'h0);
    chk("R10 hold", {16'h0, result}, {16'h0, ev});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] keep;
    int seed_dummy;
    rst_n = 1'b0; pg_wr_en = 1'b0; pg_wr_data = '0; req_valid = 1'b0;
    req_ptr = '0; req_hi = 1'b0; req_byte = 1'b0;
    seed_dummy = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset page", {16'h0, pg_rd_data}, 32'h0);
    chk("R8 reset done", {31'h0, done}, 32'h0);
    chk("R9 reset busy", {31'h0, busy}, 32'h0);
    chk("R10 reset result", {16'h0, result}, 32'h0);

    wr_page(8'hCD);
    wr_page(8'h12);
    do_read(16'h1234, 1'b0, 1'b0, 1'b0);
    do_read(16'h1235, 1'b0, 1'b0, 1'b0);
    do_read(16'h1234, 1'b0, 1'b1, 1'b0);
    do_read(16'h1235, 1'b0, 1'b1, 1'b0);
    do_read(16'h1234, 1'b1, 1'b0, 1'b0);
    do_read(16'h1234, 1'b1, 1'b1, 1'b0);
    do_read(16'h1235, 1'b1, 1'b1, 1'b0);
    // R3 pointer extremes keep the page
    do_read(16'hFFFF, 1'b0, 1'b0, 1'b0);
    do_read(16'h0000, 1'b0, 1'b0, 1'b0);
    wr_page(8'h80);
    do_read(16'h0002, 1'b1, 1'b0, 1'b0);
    chk("R2 config half", {31'h0, mem_addr[22]}, 32'h1);
    do_read(16'h4444, 1'b0, 1'b0, 1'b1);
    keep = result;
    repeat (4) @(negedge clk);
    chk("R10 long hold", {16'h0, result}, {16'h0, keep});

    for (int n = 0; n < 60; n++) begin
      if ($urandom % 4 == 0) wr_page(8'($urandom));
      do_read(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule